// File: doc/BRIEF.md
# Edge-Triggered Pulse Burst Generator

The block watches a one-bit trigger line. The first low-to-high transition it sees after reset opens a burst: a fixed number K of one-clock-wide high pulses on the output, each four clocks after the one before. After the burst the output stays low for good until the next reset. One clock cycle of this block stands for one tick, and four ticks make one period of the pulse train.

The pulse count is not held in a counter. A sticky capture latch records the edge. A one-tick line delays that capture to open a window. Two delay lines in series, N_DLY and M_DLY ticks long, feed a second sticky latch, and that latch closes the window. The window length N_DLY + M_DLY divided by four sets K. A two-bit phase counter places one pulse in each four-tick slot of the window. A retiming stage puts the first pulse six ticks after the capturing edge. Elaboration rejects a span that is zero or not a multiple of four.

Top module: `kpg_burst`

## Requirements
- R1: Only a low-to-high transition of `trig_i` starts a burst. A trigger that is already high when reset is released starts nothing until it has gone low and high again.
- R2: A burst has exactly K = (N_DLY + M_DLY) / 4 pulses. The spans 4, 8 and 16 give 1, 2 and 4 pulses.
- R3: Each pulse is high for one clock, and successive pulses of a burst rise four clocks apart.
- R4: Call the first rising clock edge that samples `trig_i` high edge 0. The first pulse is high in the cycle that follows rising edge 6 after it.
- R5: The capture is sticky. A trigger that is high for a single clock cycle still yields the full burst.
- R6: After the burst, `burst_o` stays low while the trigger stays high. It also stays low when the trigger falls and rises again, for as long as no reset comes.
- R7: Driving `rst_n` low forces `burst_o` low at once and clears every latch, delay stage and the phase counter. The release passes through a two-stage synchronizer. After release, the next rising trigger edge gives a full burst again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cycle is one tick |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_i | input | 1 | Trigger input, sampled on the rising clock edge |
| burst_o | output | 1 | Pulse burst output, registered |

## Verification
The same trigger drives three instances with spans of 8, 4 and 16, so a single stimulus checks that the pulse count follows the delay sum and not a fixed constant. A trigger held high separates a correct burst from one that keeps repeating. A fall and second rise without reset shows whether the block can be retriggered. A trigger held high across reset release separates edge detection from level detection. A one-cycle trigger pulse shows whether the capture truly holds. A scoreboard expects every pulse at an exact cycle, so an early, late, missing or extra pulse is reported as such.

// File: rtl/kpg_pkg.sv
`timescale 1ns/1ps
package kpg_pkg;
  localparam int unsigned SLOT_TICKS = 4;
  localparam int unsigned PH_W       = $clog2(SLOT_TICKS);
  localparam logic [PH_W-1:0] FIRE_PHASE = PH_W'(SLOT_TICKS - 1);
  localparam int unsigned SYNC_STAGES = 2;

  function automatic int unsigned pulses_for(input int unsigned n, input int unsigned m);
    return (n + m) / SLOT_TICKS;
  endfunction

  function automatic bit span_ok(input int unsigned n, input int unsigned m);
    return ((n + m) != 0) && (((n + m) % SLOT_TICKS) == 0);
  endfunction
endpackage

// File: rtl/kpg_rst_sync.sv
`timescale 1ns/1ps
module kpg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d[0] = 1'b1;
    for (int i = 1; i < STAGES; i++) sync_d[i] = sync_q[i-1];
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/kpg_edge_latch.sv
`timescale 1ns/1ps
module kpg_edge_latch #(
  parameter bit EDGE_ONLY = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_i,
  output logic cap_o
);
  logic set_w;
  logic cap_d;
  logic cap_q;

  generate
    if (EDGE_ONLY) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= in_i;
      end
      assign set_w = in_i & ~prev_q;
    end else begin : g_level
      assign set_w = in_i;
    end
  endgenerate

  always_comb cap_d = set_w | cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= 1'b0;
    else        cap_q <= cap_d;
  end

  assign cap_o = cap_q;

  // R6: once set, the capture holds until reset
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cap_o |=> cap_o);
  // R1: the capture only sets after the input was seen high
  a_r1_set_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_o) |-> $past(in_i));
endmodule

// File: rtl/kpg_delay_line.sv
`timescale 1ns/1ps
module kpg_delay_line #(
  parameter int unsigned DEPTH = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign q_o = d_i;
    end else begin : g_taps
      logic [DEPTH-1:0] tap_q;
      logic [DEPTH-1:0] tap_d;
      always_comb begin
        tap_d[0] = d_i;
        for (int i = 1; i < DEPTH; i++) tap_d[i] = tap_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tap_q <= '0;
        else        tap_q <= tap_d;
      end
      assign q_o = tap_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/kpg_burst.sv
`timescale 1ns/1ps
module kpg_burst
  import kpg_pkg::*;
#(
  parameter int unsigned N_DLY = 5,
  parameter int unsigned M_DLY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic burst_o
);
  localparam int unsigned SPAN   = N_DLY + M_DLY;
  localparam int unsigned PULSES = pulses_for(N_DLY, M_DLY);

  initial begin : span_check
    assert (span_ok(N_DLY, M_DLY))
      else $error("kpg_burst: N_DLY+M_DLY=%0d must be a non-zero multiple of %0d (K=%0d)",
                  SPAN, SLOT_TICKS, PULSES);
  end

  logic            rst_s_n;
  logic            armed;
  logic            lead;
  logic            span_n;
  logic            span_nm;
  logic            closed;
  logic [PH_W-1:0] ph_q, ph_d;
  logic            ph_en;
  logic            hit;
  logic            hit_q, hit_d;
  logic            out_q, out_d;

  kpg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_s_n));

  kpg_edge_latch #(.EDGE_ONLY(1'b1)) u_open (
    .clk(clk), .rst_n(rst_s_n), .in_i(trig_i), .cap_o(armed));

  kpg_delay_line #(.DEPTH(1)) u_lead (
    .clk(clk), .rst_n(rst_s_n), .d_i(armed), .q_o(lead));

  kpg_delay_line #(.DEPTH(N_DLY)) u_dly_n (
    .clk(clk), .rst_n(rst_s_n), .d_i(lead), .q_o(span_n));

  kpg_delay_line #(.DEPTH(M_DLY)) u_dly_m (
    .clk(clk), .rst_n(rst_s_n), .d_i(span_n), .q_o(span_nm));

  kpg_edge_latch #(.EDGE_ONLY(1'b0)) u_close (
    .clk(clk), .rst_n(rst_s_n), .in_i(span_nm), .cap_o(closed));

  // window gate: open AND NOT closed
  always_comb begin
    ph_en = lead & ~closed;
    ph_d  = ph_en ? ph_q + 1'b1 : ph_q;
    hit   = ph_en & (ph_q == FIRE_PHASE);
    hit_d = hit;
    out_d = hit_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ph_q  <= '0;
      hit_q <= 1'b0;
      out_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      hit_q <= hit_d;
      out_q <= out_d;
    end
  end

  assign burst_o = out_q;

  // R3: each pulse lasts exactly one clock
  a_r3_one_tick: assert property (@(posedge clk) disable iff (!rst_s_n)
    burst_o |=> !burst_o);
  // R3: no pulse inside the three clocks after a pulse
  a_r3_spacing: assert property (@(posedge clk) disable iff (!rst_s_n)
    burst_o |=> !burst_o ##1 !burst_o ##1 !burst_o);
  // R1: output pulses only once an edge has been captured
  a_r1_needs_capture: assert property (@(posedge clk) disable iff (!rst_s_n)
    burst_o |-> armed);
  // R6: a closed window emits nothing further
  a_r6_closed_quiet: assert property (@(posedge clk) disable iff (!rst_s_n)
    closed |=> !hit_q);
  // R6: phase counter freezes once the window is closed
  a_r6_phase_frozen: assert property (@(posedge clk) disable iff (!rst_s_n)
    closed |=> $stable(ph_q));
  // R2: the closing latch never sets before the opening one
  a_r2_order: assert property (@(posedge clk) disable iff (!rst_s_n)
    closed |-> lead);
endmodule

// File: tb/sim_kpg_burst.sv
`timescale 1ns/1ps
module sim_kpg_burst;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       trig;
  logic [2:0] dout;

  always #2 clk = ~clk;

  kpg_burst #(.N_DLY(5), .M_DLY(3)) u0 (.clk(clk), .rst_n(rst_n), .trig_i(trig), .burst_o(dout[0]));
  kpg_burst #(.N_DLY(1), .M_DLY(3)) u1 (.clk(clk), .rst_n(rst_n), .trig_i(trig), .burst_o(dout[1]));
  kpg_burst #(.N_DLY(9), .M_DLY(7)) u2 (.clk(clk), .rst_n(rst_n), .trig_i(trig), .burst_o(dout[2]));

  int    checks = 0;
  int    failures = 0;
  int    nc = 0;
  int    seen [3];
  int    q0[$], q1[$], q2[$];
  string req = "R1";
  bit    done = 1'b0;
  localparam int KL [3] = '{2, 1, 4};

  task automatic lane_check(ref int q[$], input int lane, input logic v);
    while (q.size() > 0 && q[0] < nc) begin
      checks++; failures++;
      $display("FAIL %s R4 lane %0d: no pulse at cycle %0d (actual 0, expected 1)", req, lane, q[0]);
      void'(q.pop_front());
    end
    if (v) begin
      checks++;
      seen[lane]++;
      if (q.size() > 0 && q[0] == nc) void'(q.pop_front());
      else begin
        failures++;
        $display("FAIL %s R3 lane %0d: pulse at cycle %0d, expected %0d", req, lane, nc,
                 (q.size() > 0) ? q[0] : -1);
      end
    end
  endtask

  // monitor
  initial forever begin
    @(negedge clk);
    nc++;
    lane_check(q0, 0, dout[0]);
    lane_check(q1, 1, dout[1]);
    lane_check(q2, 2, dout[2]);
  end

  task automatic check_eq(input string r, input int lane, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s lane %0d: actual %0d expected %0d", r, lane, act, exp);
    end
  endtask

  task automatic clear_seen();
    for (int i = 0; i < 3; i++) seen[i] = 0;
  endtask

  // driver: raise trigger and push the expected pulse cycles
  task automatic fire(input bit one_cycle);
    @(posedge clk); #1;
    trig = 1'b1;
    for (int j = 0; j < KL[0]; j++) q0.push_back(nc + 8 + 4*j);
    for (int j = 0; j < KL[1]; j++) q1.push_back(nc + 8 + 4*j);
    for (int j = 0; j < KL[2]; j++) q2.push_back(nc + 8 + 4*j);
    if (one_cycle) begin
      @(posedge clk); #1;
      trig = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    #0.5;
    for (int i = 0; i < 3; i++) check_eq("R7 reset-low output", i, int'(dout[i]), 0);
    idle(3);
    @(negedge clk);
    for (int i = 0; i < 3; i++) check_eq("R7 reset-held output", i, int'(dout[i]), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    idle(6);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0;
    trig  = 1'b0;
    clear_seen();
    #0.5;
    for (int i = 0; i < 3; i++) check_eq("R7 output at start", i, int'(dout[i]), 0);
    do_reset();

    req = "R1 idle";
    idle(12);
    for (int i = 0; i < 3; i++) check_eq("R1 no pulse without edge", i, seen[i], 0);

    req = "R2/R4 held trigger";
    clear_seen();
    fire(1'b0);
    idle(40);
    for (int i = 0; i < 3; i++) check_eq("R2 pulse count", i, seen[i], KL[i]);

    req = "R6 after burst";
    idle(20);
    @(posedge clk); #1; trig = 1'b0;
    idle(5);
    @(posedge clk); #1; trig = 1'b1;
    idle(30);
    for (int i = 0; i < 3; i++) check_eq("R6 no retrigger", i, seen[i], KL[i]);

    req = "R1 high at release";
    do_reset();
    clear_seen();
    idle(30);
    for (int i = 0; i < 3; i++) check_eq("R1 level ignored", i, seen[i], 0);
    @(posedge clk); #1; trig = 1'b0;
    idle(3);
    req = "R7 re-armed";
    fire(1'b0);
    idle(40);
    for (int i = 0; i < 3; i++) check_eq("R7 burst after reset", i, seen[i], KL[i]);

    req = "R5 short trigger";
    @(posedge clk); #1; trig = 1'b0;
    do_reset();
    clear_seen();
    fire(1'b1);
    idle(40);
    for (int i = 0; i < 3; i++) check_eq("R5 full burst from one-cycle trigger", i, seen[i], KL[i]);

    check_eq("R2 leftover expected pulses", 0, q0.size(), 0);
    check_eq("R2 leftover expected pulses", 1, q1.size(), 0);
    check_eq("R2 leftover expected pulses", 2, q2.size(), 0);
    done = 1'b1;
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: run did not finish (actual running, expected done)");
      report();
    end
  end
endmodule